// File: doc/BRIEF.md
# Error Logging and Signal Steering

This block sits beside a bus bridge and collects single-cycle error pulses from nine error sources. It records them in two capture tiers. The first tier holds the earliest error seen since software last cleared it, together with an address word captured at that moment. The second tier holds the next error that arrives while the first tier is still occupied. A two-bit summary shows which tiers currently hold something.

Recorded errors are steered to three outputs: a system-error level, an interrupt-request level and a one-cycle fatal reinitialization pulse. Each output has its own per-source enable vector. A global escalation-off bit blocks the fatal pulse. Masking affects only the outputs and never what is recorded. Software clears either tier by writing ones to the bits it wants removed.

Top module: `errlog_top`

## Requirements
- R1: After reset, both status vectors, the captured address, the summary, `sysErr`, `intr` and `fatalPulse` are all zero.
- R2: An `errIn` pulse arriving while the first tier is empty is copied in full into `firstSts`, with `errAddr` copied into `firstAddr`. Both are visible after the next rising edge. Source bit indices are: 0 address parity, 1 configuration-path internal parity, 2 read discard timer expiry, 3 hot-plug-path internal parity, 4 hot-plug controller system error, 5 observed parity-error assertion, 6 observed system-error assertion, 7 bus data parity, 8 bus-path internal parity.
- R3: While `firstSts` is non-zero, later errors change neither `firstSts` nor `firstAddr` until software clears them.
- R4: An error that arrives while the first tier is occupied and the next tier is empty is copied into `nextSts`. After that, `nextSts` keeps its value until it is cleared, and errors arriving while both tiers are occupied are dropped.
- R5: An error is recorded whatever the settings of `cfgSysErrEn`, `cfgIntrEn`, `cfgFatalEn` and `cfgEscOff`.
- R6: When `clrWrEn` is 1, each 1 in `clrData` clears that bit of `firstSts` (`clrSel`=0) or of `nextSts` (`clrSel`=1). Bits written as 0 are left unchanged.
- R7: If an error arrives in the same cycle as a clear that empties the first tier, the new error and its address are captured into the first tier.
- R8: `summary[0]` is 1 when `firstSts` is non-zero, and `summary[1]` is 1 when `nextSts` is non-zero.
- R9: `sysErr` is 1 while any bit of (`firstSts` OR `nextSts`) AND `cfgSysErrEn` is set. `intr` follows the same rule with `cfgIntrEn`. Both are levels.
- R10: `fatalPulse` is high for exactly one cycle, in the same cycle the new status first appears, when a newly recorded source is both enabled in `cfgFatalEn` and in the escalating set (default bits 1, 3 and 4). Bus data parity (bit 7) and dropped errors never pulse.
- R11: While `cfgEscOff` is 1, no fatal pulse is produced, and the error is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errIn | input | NUM_SRC | Single-cycle error pulses, one bit per source |
| errAddr | input | ADDR_W | Address word logged with a first-tier capture |
| clrWrEn | input | 1 | Write-one-to-clear strobe |
| clrSel | input | 1 | Clear target: 0 first tier, 1 next tier |
| clrData | input | NUM_SRC | Bits to clear |
| cfgSysErrEn | input | NUM_SRC | Per-source system-error enables |
| cfgIntrEn | input | NUM_SRC | Per-source interrupt enables |
| cfgFatalEn | input | NUM_SRC | Per-source fatal escalation enables |
| cfgEscOff | input | 1 | Turns off fatal escalation globally |
| firstSts | output | NUM_SRC | First-tier status |
| firstAddr | output | ADDR_W | Address logged with the first-tier error |
| nextSts | output | NUM_SRC | Next-tier status |
| summary | output | 2 | Tier occupancy: bit 0 first, bit 1 next |
| sysErr | output | 1 | System-error level |
| intr | output | 1 | Interrupt request level |
| fatalPulse | output | 1 | One-cycle fatal reinitialization pulse |

## Verification
A wrong occupancy decision shows at the ports one edge after the offending pulse. The error then lands in the wrong tier, overwrites a held first error, or is lost, and this appears directly in `firstSts`, `nextSts` and `summary`. A steering fault shows at once on `sysErr` or `intr`, because those outputs are built combinationally from the held bits. A bad fatal decision shows only in the single cycle the status appears, so the bench samples the pulse in that cycle and in the cycle after it. Clears that collide with new errors are exercised because a lost capture there would otherwise go unseen.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  typedef enum int unsigned {
    SRC_ADDR_PAR   = 0,
    SRC_CFG_PAR    = 1,
    SRC_DISCARD    = 2,
    SRC_HP_PAR     = 3,
    SRC_HP_SYSERR  = 4,
    SRC_SEEN_PERR  = 5,
    SRC_SEEN_SERR  = 6,
    SRC_BUS_DPAR   = 7,
    SRC_BUS_PAR    = 8
  } errSrcE;

  localparam int unsigned SRC_COUNT = 9;

  localparam logic [SRC_COUNT-1:0] FATAL_DEFAULT =
    SRC_COUNT'((1 << SRC_CFG_PAR) | (1 << SRC_HP_PAR) | (1 << SRC_HP_SYSERR));

  typedef struct packed {
    logic capFirst;
    logic capNext;
    logic clrFirst;
    logic clrNext;
    logic fatal;
  } logStrobeT;
endpackage

// File: rtl/errlog_ctrl.sv
module errlog_ctrl
  import errlog_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter logic [NUM_SRC-1:0] FATAL_SET = FATAL_DEFAULT
) (
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [NUM_SRC-1:0] firstSts,
  input  logic [NUM_SRC-1:0] nextSts,
  input  logic               clrWrEn,
  input  logic               clrSel,
  input  logic [NUM_SRC-1:0] clrData,
  input  logic [NUM_SRC-1:0] cfgFatalEn,
  input  logic               cfgEscOff,
  output logStrobeT          stb
);
  logic [NUM_SRC-1:0] firstLeft, nextLeft, newRec;
  logic anyErr, firstFree, nextFree;

  always_comb begin
    stb.clrFirst = clrWrEn && !clrSel;
    stb.clrNext  = clrWrEn && clrSel;
    firstLeft = stb.clrFirst ? (firstSts & ~clrData) : firstSts;
    nextLeft  = stb.clrNext  ? (nextSts  & ~clrData) : nextSts;
    anyErr    = |errIn;
    firstFree = (firstLeft == '0);
    nextFree  = (nextLeft == '0);
    stb.capFirst = anyErr && firstFree;
    stb.capNext  = anyErr && !firstFree && nextFree;
    newRec    = (stb.capFirst || stb.capNext) ? errIn : '0;
    stb.fatal = !cfgEscOff && |(newRec & cfgFatalEn & FATAL_SET);
  end
endmodule

// File: rtl/errlog_regs.sv
module errlog_regs
  import errlog_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logStrobeT          stb,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [ADDR_W-1:0]  errAddr,
  input  logic [NUM_SRC-1:0] clrData,
  input  logic [NUM_SRC-1:0] cfgSysErrEn,
  input  logic [NUM_SRC-1:0] cfgIntrEn,
  output logic [NUM_SRC-1:0] firstSts,
  output logic [ADDR_W-1:0]  firstAddr,
  output logic [NUM_SRC-1:0] nextSts,
  output logic [1:0]         summary,
  output logic               sysErr,
  output logic               intr,
  output logic               fatalPulse
);
  logic [NUM_SRC-1:0] firstKeep, nextKeep, heldAll;

  assign firstKeep = stb.clrFirst ? (firstSts & ~clrData) : firstSts;
  assign nextKeep  = stb.clrNext  ? (nextSts  & ~clrData) : nextSts;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstSts   <= '0;
      firstAddr  <= '0;
      nextSts    <= '0;
      fatalPulse <= 1'b0;
    end else begin
      if (stb.capFirst) begin
        firstSts  <= errIn;
        firstAddr <= errAddr;
      end else begin
        firstSts  <= firstKeep;
      end
      nextSts    <= stb.capNext ? errIn : nextKeep;
      fatalPulse <= stb.fatal;
    end
  end

  assign heldAll = firstSts | nextSts;
  assign summary = {|nextSts, |firstSts};
  assign sysErr  = |(heldAll & cfgSysErrEn);
  assign intr    = |(heldAll & cfgIntrEn);

  p_first_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errIn != '0 && firstSts == '0) |=> (firstSts == $past(errIn)));

  p_first_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (firstSts != '0 && !stb.clrFirst) |=> ($stable(firstSts) && $stable(firstAddr)));

  p_next_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (nextSts != '0 && !stb.clrNext) |=> $stable(nextSts));
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter int unsigned ADDR_W  = 16,
  parameter logic [NUM_SRC-1:0] FATAL_SET = FATAL_DEFAULT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [ADDR_W-1:0]  errAddr,
  input  logic               clrWrEn,
  input  logic               clrSel,
  input  logic [NUM_SRC-1:0] clrData,
  input  logic [NUM_SRC-1:0] cfgSysErrEn,
  input  logic [NUM_SRC-1:0] cfgIntrEn,
  input  logic [NUM_SRC-1:0] cfgFatalEn,
  input  logic               cfgEscOff,
  output logic [NUM_SRC-1:0] firstSts,
  output logic [ADDR_W-1:0]  firstAddr,
  output logic [NUM_SRC-1:0] nextSts,
  output logic [1:0]         summary,
  output logic               sysErr,
  output logic               intr,
  output logic               fatalPulse
);
  logStrobeT stb;

  errlog_ctrl #(.NUM_SRC(NUM_SRC), .FATAL_SET(FATAL_SET)) u_ctrl (
    .errIn(errIn), .firstSts(firstSts), .nextSts(nextSts),
    .clrWrEn(clrWrEn), .clrSel(clrSel), .clrData(clrData),
    .cfgFatalEn(cfgFatalEn), .cfgEscOff(cfgEscOff), .stb(stb)
  );

  errlog_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .errIn(errIn), .errAddr(errAddr),
    .clrData(clrData), .cfgSysErrEn(cfgSysErrEn), .cfgIntrEn(cfgIntrEn),
    .firstSts(firstSts), .firstAddr(firstAddr), .nextSts(nextSts),
    .summary(summary), .sysErr(sysErr), .intr(intr), .fatalPulse(fatalPulse)
  );

  p_esc_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgEscOff |=> !fatalPulse);
endmodule

// File: tb/sim_errlog_top.sv
module sim_errlog_top;
  localparam int unsigned N  = 9;
  localparam int unsigned AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] errIn = '0, clrData = '0;
  logic [AW-1:0] errAddr = '0;
  logic clrWrEn = 1'b0, clrSel = 1'b0, cfgEscOff = 1'b0;
  logic [N-1:0] cfgSysErrEn = '0, cfgIntrEn = '0, cfgFatalEn = '0;
  logic [N-1:0] firstSts, nextSts;
  logic [AW-1:0] firstAddr;
  logic [1:0] summary;
  logic sysErr, intr, fatalPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  errlog_top u0 (
    .clk(clk), .rstN(rstN), .errIn(errIn), .errAddr(errAddr),
    .clrWrEn(clrWrEn), .clrSel(clrSel), .clrData(clrData),
    .cfgSysErrEn(cfgSysErrEn), .cfgIntrEn(cfgIntrEn), .cfgFatalEn(cfgFatalEn),
    .cfgEscOff(cfgEscOff), .firstSts(firstSts), .firstAddr(firstAddr),
    .nextSts(nextSts), .summary(summary), .sysErr(sysErr), .intr(intr),
    .fatalPulse(fatalPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] e, input logic [AW-1:0] a);
    errIn = e; errAddr = a;
    @(negedge clk);
    errIn = '0;
  endtask

  task automatic clear(input logic sel, input logic [N-1:0] d);
    clrWrEn = 1'b1; clrSel = sel; clrData = d;
    @(negedge clk);
    clrWrEn = 1'b0; clrData = '0;
  endtask

  task automatic clearAll();
    clear(1'b0, '1);
    clear(1'b1, '1);
  endtask

  task automatic tReset();
    chk("R1 firstSts", 32'(firstSts), 0);
    chk("R1 nextSts", 32'(nextSts), 0);
    chk("R1 firstAddr", 32'(firstAddr), 0);
    chk("R1 summary", 32'(summary), 0);
    chk("R1 sysErr/intr/fatal", {29'd0, sysErr, intr, fatalPulse}, 0);
  endtask

  task automatic tFirstCapture();
    pulse(9'h081, 16'h1234);
    chk("R2 firstSts", 32'(firstSts), 32'h081);
    chk("R2 firstAddr", 32'(firstAddr), 32'h1234);
    chk("R8 summary first only", 32'(summary), 1);
    chk("R5 masked sysErr", 32'(sysErr), 0);
    chk("R5 masked intr", 32'(intr), 0);
  endtask

  task automatic tHoldNext();
    pulse(9'h004, 16'h5555);
    chk("R3 firstSts held", 32'(firstSts), 32'h081);
    chk("R3 firstAddr held", 32'(firstAddr), 32'h1234);
    chk("R4 nextSts", 32'(nextSts), 32'h004);
    chk("R8 summary both", 32'(summary), 3);
    pulse(9'h100, 16'h7777);
    chk("R4 nextSts frozen", 32'(nextSts), 32'h004);
    chk("R3 firstSts still held", 32'(firstSts), 32'h081);
  endtask

  task automatic tSteer();
    cfgSysErrEn = 9'h004;
    @(negedge clk);
    chk("R9 sysErr from next tier", 32'(sysErr), 1);
    chk("R9 intr off", 32'(intr), 0);
    cfgIntrEn = 9'h001;
    cfgSysErrEn = '0;
    @(negedge clk);
    chk("R9 intr from first tier", 32'(intr), 1);
    chk("R9 sysErr off", 32'(sysErr), 0);
  endtask

  task automatic tClear();
    clear(1'b0, 9'h001);
    chk("R6 partial clear first", 32'(firstSts), 32'h080);
    chk("R9 intr drops after clear", 32'(intr), 0);
    chk("R6 next untouched", 32'(nextSts), 32'h004);
    clear(1'b1, 9'h004);
    chk("R6 clear next", 32'(nextSts), 0);
    chk("R8 summary after next clear", 32'(summary), 1);
    clear(1'b0, 9'h080);
    chk("R8 summary empty", 32'(summary), 0);
    cfgIntrEn = '0;
  endtask

  task automatic tCollide();
    pulse(9'h002, 16'h0AAA);
    chk("R7 setup first", 32'(firstSts), 32'h002);
    errIn = 9'h010; errAddr = 16'h0BBB;
    clrWrEn = 1'b1; clrSel = 1'b0; clrData = 9'h002;
    @(negedge clk);
    errIn = '0; clrWrEn = 1'b0; clrData = '0;
    chk("R7 captured during clear", 32'(firstSts), 32'h010);
    chk("R7 address during clear", 32'(firstAddr), 32'h0BBB);
    chk("R7 not sent to next", 32'(nextSts), 0);
    clearAll();
  endtask

  task automatic tFatal();
    cfgFatalEn = '1;
    pulse(9'h008, 16'h0001);
    chk("R10 fatal pulse hp parity", 32'(fatalPulse), 1);
    @(negedge clk);
    chk("R10 fatal one cycle", 32'(fatalPulse), 0);
    pulse(9'h001, 16'h0002);
    chk("R10 addr parity no fatal", 32'(fatalPulse), 0);
    clearAll();
    pulse(9'h080, 16'h0003);
    chk("R10 bus data parity no fatal", 32'(fatalPulse), 0);
    chk("R10 bus data parity recorded", 32'(firstSts), 32'h080);
    pulse(9'h010, 16'h0004);
    chk("R10 fatal from next tier", 32'(fatalPulse), 1);
    pulse(9'h008, 16'h0005);
    chk("R10 dropped error no fatal", 32'(fatalPulse), 0);
    chk("R4 dropped error not recorded", 32'(nextSts), 32'h010);
    clearAll();
  endtask

  task automatic tEscOff();
    cfgEscOff = 1'b1;
    pulse(9'h002, 16'h0006);
    chk("R11 escalation off no fatal", 32'(fatalPulse), 0);
    chk("R11 still recorded", 32'(firstSts), 32'h002);
    clearAll();
    cfgEscOff = 1'b0;
    cfgFatalEn = '0;
    pulse(9'h008, 16'h0007);
    chk("R5 fatal enable off no pulse", 32'(fatalPulse), 0);
    chk("R5 recorded with enable off", 32'(firstSts), 32'h008);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFirstCapture();
    tHoldNext();
    tSteer();
    tClear();
    tCollide();
    tFatal();
    tEscOff();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule